// File: doc/BRIEF.md
# Segment Column Driver Command and Display Memory Interface

This block is the slave side of one 64-column segment driver. A host reaches it over a parallel byte bus that uses a strobe, a chip select, a register/data select (`bus_rs`) and a read/write select (`bus_rw`). The strobe is sampled by the block clock, and every action takes place on the clock edge where the strobe is first seen low after being high. The block decodes instruction bytes that set the display on or off, the column, the page and the first displayed line. It keeps a display memory of 8 pages by 64 columns of bytes. It also reports a status byte that holds busy, display-off and reset indications.

Data accesses use the current page and column. After every data write or data read the column moves forward by one and wraps to 0. The page never moves by itself. Reads go through an output latch. A data read shows the latch on the bus, and then the falling strobe refills the latch from memory at the current address. So the first read after any address load returns stale data and serves as a dummy read. The start line and the on/off state are output to the refresh logic, which lies outside this block.

Within each memory byte, bit 0 holds the top row of its 8-row page and bit 7 holds the bottom row. After each accepted access the block stays busy for a fixed number of clocks. During that time only status reads have any effect.

Top module: `segdrv_regif`

## Requirements
- R1: While `rst_n` is low the display is off and `start_line` is 0. A status read during reset returns 0xB0 (busy, off and reset set). After release, page, column, start line and output latch are all 0.
- R2: The instruction byte 0011111D with rs=0, rw=0 sets `disp_on` to D (1 means on). It does not change memory contents.
- R3: The instruction byte 11LLLLLL loads the 6-bit field L into `start_line`.
- R4: The instruction 01CCCCCC loads the column with C. The instruction 10111PPP loads the page with P. A data write (rs=1, rw=0) stores the byte at (page, column).
- R5: Each accepted data write or data read increments the column by one, and column 63 wraps to 0. Neither access changes the page.
- R6: A data read (rs=1, rw=1) drives the current output latch on `bus_rdata` while the strobe is high. On the falling strobe the latch is reloaded from memory at (page, column) before that column is incremented.
- R7: A status read (rs=0, rw=1) drives bit 7 = busy, bit 5 = display off and bit 4 = reset held. Bits 6 and 3..0 read 0.
- R8: An accepted access holds busy for BUSY_CYC clocks. Any non-status access whose strobe falls while busy is ignored.
- R9: With `bus_cs` low, no access changes any state and `bus_rdata` reads 0.
- R10: Select, direction and data are taken at the clock where the strobe is first seen low. Values driven earlier in the same strobe are not used.
- R11: Instructions and data accesses issued while `rst_n` is low have no effect after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus strobe is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, acts regardless of chip select |
| bus_e | input | 1 | Bus strobe; the action happens on its sampled falling edge |
| bus_cs | input | 1 | Chip select, active high |
| bus_rs | input | 1 | 1 selects data memory, 0 selects instruction/status |
| bus_rw | input | 1 | 1 selects read, 0 selects write |
| bus_wdata | input | 8 | Instruction or write data byte |
| bus_rdata | output | 8 | Status or output latch while a selected read strobe is high, else 0 |
| disp_on | output | 1 | Display on state for the refresh logic |
| start_line | output | 6 | First displayed memory line for the refresh logic |

## Verification
The bench builds the block with the default 64-column, 8-page geometry and with BUSY_CYC raised to 10. With 64 columns, a single column load to 63 followed by two data accesses exercises the wrap to 0. The longer busy window lets a bus access issued back-to-back at normal strobe speed fall inside the busy period, so the ignored-access rule can be observed through a later readback and through the busy bit of a status read.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  localparam int BUS_W = 8;

  // access kind is the pair {rs, rw}
  typedef enum logic [1:0] {
    ACC_INSTR  = 2'b00,
    ACC_STATUS = 2'b01,
    ACC_WRITE  = 2'b10,
    ACC_READ   = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ONOFF,
    OP_COL,
    OP_PAGE,
    OP_START
  } op_e;

  function automatic op_e decode_instr(input logic [BUS_W-1:0] b);
    if (b[7:1] == 7'b0011111)     return OP_ONOFF;
    else if (b[7:6] == 2'b01)     return OP_COL;
    else if (b[7:3] == 5'b10111)  return OP_PAGE;
    else if (b[7:6] == 2'b11)     return OP_START;
    else                          return OP_NONE;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(input logic busy,
                                                   input logic off,
                                                   input logic in_rst);
    return {busy, 1'b0, off, in_rst, 4'b0000};
  endfunction

endpackage

// File: rtl/segdrv_strobe.sv
module segdrv_strobe
  import segdrv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic e_i,
  input  logic cs_i,
  input  logic rs_i,
  input  logic rw_i,
  output logic fall_o,
  output logic sel_o,
  output acc_e kind_o
);

  logic e_q;

  always_ff @(posedge clk) begin
    if (!rst_n) e_q <= 1'b0;
    else        e_q <= e_i;
  end

  assign fall_o = e_q & ~e_i;
  assign sel_o  = fall_o & cs_i;
  assign kind_o = acc_e'({rs_i, rw_i});

endmodule

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int BUSY_CYC = 8,
  localparam int CW  = $clog2(COLS),
  localparam int PW  = $clog2(PAGES),
  localparam int SLW = $clog2(PAGES * 8),
  localparam int BW  = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  acc_e             kind_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [PW-1:0]    page_o,
  output logic [CW-1:0]    col_o,
  output logic [SLW-1:0]   start_o,
  output logic             disp_on_o,
  output logic             busy_o
);

  logic [BW-1:0] busy_cnt;
  op_e           op;
  logic          is_instr;
  logic          data_step;

  function automatic logic [CW-1:0] col_next(input logic [CW-1:0] c);
    return (c == CW'(COLS - 1)) ? '0 : c + 1'b1;
  endfunction

  assign op        = decode_instr(wdata_i);
  assign is_instr  = accept_i && (kind_i == ACC_INSTR);
  assign data_step = accept_i && ((kind_i == ACC_WRITE) || (kind_i == ACC_READ));
  assign busy_o    = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      page_o    <= '0;
      col_o     <= '0;
      start_o   <= '0;
      disp_on_o <= 1'b0;
    end else begin
      if (accept_i)            busy_cnt <= BW'(BUSY_CYC);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

      if (data_step)                        col_o <= col_next(col_o);
      else if (is_instr && op == OP_COL)    col_o <= wdata_i[CW-1:0];

      if (is_instr) begin
        case (op)
          OP_ONOFF: disp_on_o <= wdata_i[0];
          OP_PAGE:  page_o    <= wdata_i[PW-1:0];
          OP_START: start_o   <= wdata_i[SLW-1:0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/segdrv_ram.sv
module segdrv_ram
  import segdrv_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int PAGES = 8,
  localparam int CW    = $clog2(COLS),
  localparam int PW    = $clog2(PAGES),
  localparam int DEPTH = COLS * PAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [PW-1:0]    page_i,
  input  logic [CW-1:0]    col_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] latch_o
);

  logic [BUS_W-1:0] mem [DEPTH];
  logic [PW+CW-1:0] idx;

  assign idx = {page_i, col_i};

  always_ff @(posedge clk) begin
    if (we_i) mem[idx] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    latch_o <= '0;
    else if (re_i) latch_o <= mem[idx];
  end

endmodule

// File: rtl/segdrv_regif.sv
module segdrv_regif
  import segdrv_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int BUSY_CYC = 8,
  localparam int CW  = $clog2(COLS),
  localparam int PW  = $clog2(PAGES),
  localparam int SLW = $clog2(PAGES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_e,
  input  logic             bus_cs,
  input  logic             bus_rs,
  input  logic             bus_rw,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             disp_on,
  output logic [SLW-1:0]   start_line
);

  logic             strb_fall;
  logic             strb_sel;
  acc_e             kind;
  logic             busy;
  logic             acc_ok;
  logic             data_step;
  logic             ram_we;
  logic             ram_re;
  logic [PW-1:0]    page;
  logic [CW-1:0]    col;
  logic [BUS_W-1:0] out_latch;
  logic [BUS_W-1:0] status;

  segdrv_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .e_i    (bus_e),
    .cs_i   (bus_cs),
    .rs_i   (bus_rs),
    .rw_i   (bus_rw),
    .fall_o (strb_fall),
    .sel_o  (strb_sel),
    .kind_o (kind)
  );

  // status reads never count as accepted accesses
  assign acc_ok    = strb_sel && rst_n && !busy && (kind != ACC_STATUS);
  assign data_step = acc_ok && kind[1];
  assign ram_we    = acc_ok && (kind == ACC_WRITE);
  assign ram_re    = acc_ok && (kind == ACC_READ);

  segdrv_ctrl #(
    .COLS     (COLS),
    .PAGES    (PAGES),
    .BUSY_CYC (BUSY_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (acc_ok),
    .kind_i    (kind),
    .wdata_i   (bus_wdata),
    .page_o    (page),
    .col_o     (col),
    .start_o   (start_line),
    .disp_on_o (disp_on),
    .busy_o    (busy)
  );

  segdrv_ram #(
    .COLS  (COLS),
    .PAGES (PAGES)
  ) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .page_i  (page),
    .col_i   (col),
    .wdata_i (bus_wdata),
    .latch_o (out_latch)
  );

  assign status = pack_status(busy || !rst_n, !disp_on, !rst_n);

  always_comb begin
    bus_rdata = '0;
    if (bus_e && bus_cs && bus_rw)
      bus_rdata = bus_rs ? out_latch : status;
  end

endmodule

// File: rtl/segdrv_regif_chk.sv
module segdrv_regif_chk #(
  parameter int CW  = 6,
  parameter int PW  = 3,
  parameter int SLW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_e,
  input logic           bus_cs,
  input logic           bus_rs,
  input logic           bus_rw,
  input logic [7:0]     bus_rdata,
  input logic           strb_fall,
  input logic           acc_ok,
  input logic           data_step,
  input logic           busy,
  input logic [PW-1:0]  page,
  input logic [CW-1:0]  col,
  input logic [SLW-1:0] start_line,
  input logic           disp_on
);

  logic rst_low_q;

  always_ff @(posedge clk) rst_low_q <= !rst_n;

  always @(negedge clk) begin
    if (rst_low_q === 1'b1)
      AST_RST_OFF: assert (disp_on == 1'b0 && start_line == '0); // R1
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_step |=> (col == $past(col) + 1'b1)); // R5

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_step |=> $stable(page)); // R5

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_e && bus_cs && !bus_rs && bus_rw) |-> (bus_rdata[6] == 1'b0 && bus_rdata[3:0] == 4'h0)); // R7

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> busy); // R8

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && bus_cs && busy && !(!bus_rs && bus_rw)) |=>
      ($stable(col) && $stable(page) && $stable(start_line) && $stable(disp_on))); // R8

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !bus_cs) |=>
      ($stable(col) && $stable(page) && $stable(start_line) && $stable(disp_on))); // R9

endmodule

bind segdrv_regif segdrv_regif_chk #(.CW(CW), .PW(PW), .SLW(SLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_e      (bus_e),
  .bus_cs     (bus_cs),
  .bus_rs     (bus_rs),
  .bus_rw     (bus_rw),
  .bus_rdata  (bus_rdata),
  .strb_fall  (strb_fall),
  .acc_ok     (acc_ok),
  .data_step  (data_step),
  .busy       (busy),
  .page       (page),
  .col        (col),
  .start_line (start_line),
  .disp_on    (disp_on)
);

// File: tb/segdrv_regif_tb.sv
module segdrv_regif_tb;

  localparam int BUSY = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e = 1'b0, cs = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       disp_on;
  logic [5:0] start_line;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  segdrv_regif #(.BUSY_CYC(BUSY)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_e      (e),
    .bus_cs     (cs),
    .bus_rs     (rs),
    .bus_rw     (rw),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .disp_on    (disp_on),
    .start_line (start_line)
  );

  // {rs, rw, data, check, expected}
  localparam logic [18:0] VEC [12] = '{
    {1'b0, 1'b0, 8'h3F, 1'b0, 8'h00},  // display on
    {1'b0, 1'b0, 8'hBA, 1'b0, 8'h00},  // page 2
    {1'b0, 1'b0, 8'h45, 1'b0, 8'h00},  // column 5
    {1'b1, 1'b0, 8'hA5, 1'b0, 8'h00},  // write (2,5)
    {1'b1, 1'b0, 8'h3C, 1'b0, 8'h00},  // write (2,6)
    {1'b0, 1'b0, 8'h45, 1'b0, 8'h00},  // column 5
    {1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // dummy read
    {1'b1, 1'b1, 8'h00, 1'b1, 8'hA5},  // R6 read (2,5)
    {1'b1, 1'b1, 8'h00, 1'b1, 8'h3C},  // R6 read (2,6)
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R7 status: on, idle
    {1'b0, 1'b0, 8'hC9, 1'b0, 8'h00},  // start line 9
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h00}   // R7 status again
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic r, input logic w, input logic [7:0] d,
                     input int gap, output logic [7:0] rd);
    @(negedge clk); cs = c; rs = r; rw = w; wdata = d; e = 1'b1;
    @(negedge clk); rd = rdata;
    @(negedge clk); e = 1'b0;
    @(negedge clk); cs = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check8("R1 disp_on in reset", {7'd0, disp_on}, 8'h00);
    check8("R1 start_line in reset", {2'd0, start_line}, 8'h00);
    bus(1'b1, 1'b0, 1'b1, 8'h00, 0, rd);
    check8("R1 R7 status in reset", rd, 8'hB0);
    // R11: instructions during reset are dropped
    bus(1'b1, 1'b0, 1'b0, 8'h3F, 0, rd);
    bus(1'b1, 1'b0, 1'b0, 8'hC7, 0, rd);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check8("R11 disp_on after reset", {7'd0, disp_on}, 8'h00);
    check8("R11 start_line after reset", {2'd0, start_line}, 8'h00);
    bus(1'b1, 1'b0, 1'b1, 8'h00, BUSY, rd);
    check8("R1 status after release", rd, 8'h20);

    // table: R4 R6 R7
    foreach (VEC[i]) begin
      bus(1'b1, VEC[i][18], VEC[i][17], VEC[i][16:9], BUSY, rd);
      if (VEC[i][8]) check8($sformatf("R4 R6 R7 vector %0d", i), rd, VEC[i][7:0]);
    end
    check8("R3 start_line", {2'd0, start_line}, 8'h09);
    check8("R2 display on", {7'd0, disp_on}, 8'h01);

    // R2: display off keeps memory
    bus(1'b1, 1'b0, 1'b0, 8'h3E, BUSY, rd);
    check8("R2 display off", {7'd0, disp_on}, 8'h00);
    bus(1'b1, 1'b0, 1'b1, 8'h00, BUSY, rd);
    check8("R7 status off", rd, 8'h20);
    bus(1'b1, 1'b0, 1'b0, 8'h45, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    check8("R2 memory kept", rd, 8'hA5);

    // R5: wrap 63 -> 0, page held
    bus(1'b1, 1'b0, 1'b0, 8'hB9, BUSY, rd);
    bus(1'b1, 1'b0, 1'b0, 8'h7F, BUSY, rd);
    bus(1'b1, 1'b1, 1'b0, 8'h11, BUSY, rd);
    bus(1'b1, 1'b1, 1'b0, 8'h22, BUSY, rd);
    bus(1'b1, 1'b0, 1'b0, 8'h7F, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    check8("R5 column 63", rd, 8'h11);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    check8("R5 wrapped column 0", rd, 8'h22);

    // R8: busy window
    bus(1'b1, 1'b0, 1'b0, 8'hBB, BUSY, rd);
    bus(1'b1, 1'b0, 1'b0, 8'h4A, BUSY, rd);
    bus(1'b1, 1'b1, 1'b0, 8'h5A, 0, rd);
    bus(1'b1, 1'b0, 1'b1, 8'h00, 0, rd);
    check8("R8 status busy", rd, 8'hA0);
    bus(1'b1, 1'b0, 1'b0, 8'hBF, BUSY, rd);   // page 7, falls while busy
    bus(1'b1, 1'b0, 1'b1, 8'h00, BUSY, rd);
    check8("R8 busy cleared", rd, 8'h20);
    bus(1'b1, 1'b0, 1'b0, 8'h4A, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    bus(1'b1, 1'b1, 1'b1, 8'h00, BUSY, rd);
    check8("R8 page load ignored", rd, 8'h5A);

    // R10: byte present at the falling strobe is used
    @(negedge clk); cs = 1'b1; rs = 1'b0; rw = 1'b0; wdata = 8'hC1; e = 1'b1;
    @(negedge clk); wdata = 8'hC3;
    @(negedge clk); e = 1'b0; wdata = 8'hC2;
    @(negedge clk); cs = 1'b0;
    repeat (BUSY) @(negedge clk);
    check8("R10 captured at fall", {2'd0, start_line}, 8'h02);

    // R9: chip select low
    bus(1'b0, 1'b0, 1'b0, 8'h3F, BUSY, rd);
    check8("R9 no instruction", {7'd0, disp_on}, 8'h00);
    bus(1'b0, 1'b1, 1'b1, 8'h00, BUSY, rd);
    check8("R9 data read idle bus", rd, 8'h00);
    bus(1'b0, 1'b0, 1'b1, 8'h00, BUSY, rd);
    check8("R9 status idle bus", rd, 8'h00);

    // R1: reset mid-run forces off
    bus(1'b1, 1'b0, 1'b0, 8'h3F, BUSY, rd);
    check8("R2 on before reset", {7'd0, disp_on}, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check8("R1 reset forces off", {7'd0, disp_on}, 8'h00);
    check8("R1 reset clears start", {2'd0, start_line}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule